// File: doc/BRIEF.md
# Transmit Dominant Guard

This block sits in the transmit path of a CAN transceiver, between the transmit-data input from the protocol controller and the enable of the bus driver. A low level on transmit data asks for a dominant bus state, and a high level asks for recessive. The block passes that request to the driver only while the transceiver is in normal mode and no lockout is active.

Two lockouts protect the bus and the chip. The first is a dominant timeout. A falling edge on the synchronized transmit data starts a cycle counter. If the line stays low for the whole timeout, the driver is switched off and the bus is left recessive. The second is a thermal lockout, set by an overtemperature flag. The flag ends only the transmitter's activity; the timeout logic keeps running. Neither lockout clears by itself. Both are released when transmit data returns high: for the timeout, this holds even if the low level lasted a long time; for the thermal lockout, it holds even after the temperature flag has dropped.

Both asynchronous inputs pass through a reset-to-safe synchronizer before any edge is detected. The transmit-data stage resets to recessive, so an input that is undriven or low at reset does not turn the driver on.

Top module: `txd_dom_guard`

## Requirements
- R1: After reset, `drv_en_o`, `tmo_lock_o` and `therm_lock_o` are all 0, and the internal transmit-data level is recessive (1).
- R2: `drv_en_o` is 1 exactly when `normal_mode_i` is 1, the synchronized transmit data is 0 (dominant), and neither lockout is set. A change on `txd_i` reaches `drv_en_o` after SYNC_STAGES clock edges.
- R3: A falling edge on the synchronized transmit data starts the timer. While the line stays low, `drv_en_o` stays 1 for exactly TMO_CYCLES cycles. After that, `tmo_lock_o` becomes 1 and `drv_en_o` becomes 0.
- R4: `tmo_lock_o` stays 1 while transmit data stays low. It clears SYNC_STAGES+1 edges after `txd_i` rises. A low phase that ends before expiry resets the timer, so the next falling edge gets a full TMO_CYCLES again.
- R5: The timer runs whatever the level of `normal_mode_i`. A timeout that expired outside normal mode keeps the driver off when normal mode returns.
- R6: `therm_lock_o` becomes 1 SYNC_STAGES+1 edges after `overtemp_i` rises, and `drv_en_o` is then 0.
- R7: `therm_lock_o` stays 1 after `overtemp_i` falls. It clears only on a rising edge of the synchronized transmit data that is seen while the synchronized overtemperature flag is 0. If the flag is still 1 at that moment, the lockout stays set.
- R8: An active thermal lockout does not stop the timeout function: `tmo_lock_o` still sets after TMO_CYCLES low cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txd_i | input | 1 | Raw transmit data; 0 requests dominant |
| overtemp_i | input | 1 | Raw overtemperature flag, active high |
| normal_mode_i | input | 1 | Synchronous qualifier; 1 when the transceiver is in normal mode |
| drv_en_o | output | 1 | Gated bus-driver enable |
| tmo_lock_o | output | 1 | Dominant-timeout lockout status |
| therm_lock_o | output | 1 | Thermal lockout status |

## Verification
The bench builds the block with SYNC_STAGES=2, TMO_CYCLES=200 and a 500 kHz nominal clock. With these values, the bit-rate check at elaboration still passes, and each full timeout expiry fits in a few hundred cycles. This lets a single run cover:
- exact expiry at the boundary cycle;
- restart of the timer after a short high phase;
- expiry outside normal mode;
- overlap of the thermal lockout with a running timeout.

With two synchronizer stages, every latency the bench checks is small and fixed, so each boundary can be checked on the exact cycle.

// File: rtl/txg_pkg.sv
package txg_pkg;
   localparam logic TXD_DOMINANT  = 1'b0;
   localparam logic TXD_RECESSIVE = 1'b1;

   typedef struct packed {
      logic tmo;
      logic therm;
   } txg_lock_t;
endpackage

// File: rtl/txg_sync.sv
module txg_sync #(
   parameter int                 WIDTH   = 1,
   parameter int                 STAGES  = 2,
   parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stg [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("txg_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("txg_sync: WIDTH must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/txg_edge.sv
module txg_edge #(
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic rise,
   output logic fall
);
   logic lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= RST_VAL;
      else        lvl_q <= lvl;
   end

   assign rise = lvl & ~lvl_q;
   assign fall = ~lvl & lvl_q;
endmodule

// File: rtl/txg_dom_timer.sv
module txg_dom_timer #(
   parameter int TMO_CYCLES = 20000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic txd_lvl,
   input  logic txd_rise,
   input  logic txd_fall,
   output logic lock
);
   import txg_pkg::*;

   localparam int CNT_W = $clog2(TMO_CYCLES + 1);
   localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(TMO_CYCLES - 1);
   localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

   logic [CNT_W-1:0] cnt;
   logic             running;

   assign running = (txd_lvl == TXD_DOMINANT) && (cnt != '0) && !lock;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         lock <= 1'b0;
      end else if (txd_rise) begin
         cnt  <= '0;
         lock <= 1'b0;
      end else if (txd_fall) begin
         cnt  <= ONE;
         lock <= 1'b0;
      end else if (running) begin
         cnt <= cnt + ONE;
         if (cnt == LAST_CNT) lock <= 1'b1;
      end
   end
endmodule

// File: rtl/txg_therm_latch.sv
module txg_therm_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic ot_lvl,
   input  logic txd_rise,
   output logic lock
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        lock <= 1'b0;
      else if (ot_lvl)   lock <= 1'b1;
      else if (txd_rise) lock <= 1'b0;
   end
endmodule

// File: rtl/txd_dom_guard.sv
module txd_dom_guard #(
   parameter int SYNC_STAGES  = 2,
   parameter int TMO_CYCLES   = 20000,
   parameter int CLK_HZ       = 20_000_000,
   parameter int MIN_BIT_RATE = 40_000,
   parameter int DOM_RUN_BITS = 11
) (
   input  logic clk,
   input  logic rst_n,
   input  logic txd_i,
   input  logic overtemp_i,
   input  logic normal_mode_i,
   output logic drv_en_o,
   output logic tmo_lock_o,
   output logic therm_lock_o
);
   import txg_pkg::*;

   localparam longint MIN_TMO =
      (longint'(CLK_HZ) * longint'(DOM_RUN_BITS)) / longint'(MIN_BIT_RATE);

   generate
      if (TMO_CYCLES < 2) begin : g_bad_tmo
         $error("txd_dom_guard: TMO_CYCLES must be at least 2");
      end
      if (longint'(TMO_CYCLES) <= MIN_TMO) begin : g_tmo_short
         $error("txd_dom_guard: timeout shorter than longest legal dominant run");
      end
   endgenerate

   logic [1:0] raw_in, sync_out;
   logic       txd_sync, ot_sync;
   logic       txd_rise, txd_fall;
   txg_lock_t  lk;

   assign raw_in = {overtemp_i, txd_i};

   txg_sync #(
      .WIDTH  (2),
      .STAGES (SYNC_STAGES),
      .RST_VAL({1'b0, TXD_RECESSIVE})
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (raw_in),
      .q    (sync_out)
   );

   assign txd_sync = sync_out[0];
   assign ot_sync  = sync_out[1];

   txg_edge #(.RST_VAL(TXD_RECESSIVE)) u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .lvl  (txd_sync),
      .rise (txd_rise),
      .fall (txd_fall)
   );

   txg_dom_timer #(.TMO_CYCLES(TMO_CYCLES)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .txd_lvl (txd_sync),
      .txd_rise(txd_rise),
      .txd_fall(txd_fall),
      .lock    (lk.tmo)
   );

   txg_therm_latch u_therm (
      .clk     (clk),
      .rst_n   (rst_n),
      .ot_lvl  (ot_sync),
      .txd_rise(txd_rise),
      .lock    (lk.therm)
   );

   assign drv_en_o     = normal_mode_i && (txd_sync == TXD_DOMINANT) && (lk == '0);
   assign tmo_lock_o   = lk.tmo;
   assign therm_lock_o = lk.therm;
endmodule

// File: rtl/txg_checker.sv
module txg_checker #(
   parameter int TMO_CYCLES = 20000
) (
   input logic clk,
   input logic rst_n,
   input logic normal_mode_i,
   input logic drv_en_o,
   input logic tmo_lock_o,
   input logic therm_lock_o,
   input logic txd_s,
   input logic ot_s
);
   localparam int RUN_W = $clog2(TMO_CYCLES + 2);
   localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(TMO_CYCLES + 1);

   logic [RUN_W-1:0] run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            run <= '0;
      else if (!drv_en_o)    run <= '0;
      else if (run != RUN_MAX) run <= run + RUN_W'(1);
   end

   a_r2_off_when_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (tmo_lock_o || therm_lock_o || !normal_mode_i) |-> !drv_en_o);

   a_r3_max_dominant_run: assert property (@(posedge clk) disable iff (!rst_n)
      drv_en_o |-> (run < RUN_W'(TMO_CYCLES)));

   a_r4_tmo_release_on_high: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tmo_lock_o) |-> $past(txd_s));

   a_r6_therm_sets: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ot_s) |-> therm_lock_o);

   a_r7_therm_release: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(therm_lock_o) |-> ($past(txd_s) && !$past(ot_s)));
endmodule

bind txd_dom_guard txg_checker #(.TMO_CYCLES(TMO_CYCLES)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .normal_mode_i(normal_mode_i),
   .drv_en_o     (drv_en_o),
   .tmo_lock_o   (tmo_lock_o),
   .therm_lock_o (therm_lock_o),
   .txd_s        (txd_sync),
   .ot_s         (ot_sync)
);

// File: tb/txd_dom_guard_tb.sv
module txd_dom_guard_tb;
   localparam int CLK_PERIOD = 10;
   localparam int SYNC       = 2;
   localparam int TMO        = 200;
   localparam int WD_CYCLES  = 100000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic txd = 1'b1;
   logic ot = 1'b0;
   logic nm = 1'b1;
   logic drv_en, tmo_lock, therm_lock;

   int n_checks = 0;
   int n_fail   = 0;
   int cyc_cnt  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   txd_dom_guard #(
      .SYNC_STAGES (SYNC),
      .TMO_CYCLES  (TMO),
      .CLK_HZ      (500_000),
      .MIN_BIT_RATE(40_000),
      .DOM_RUN_BITS(11)
   ) u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .txd_i        (txd),
      .overtemp_i   (ot),
      .normal_mode_i(nm),
      .drv_en_o     (drv_en),
      .tmo_lock_o   (tmo_lock),
      .therm_lock_o (therm_lock)
   );

   always @(posedge clk) begin
      cyc_cnt <= cyc_cnt + 1;
      if (cyc_cnt == WD_CYCLES) begin
         n_checks = n_checks + 1;
         n_fail   = n_fail + 1;
         $display("FAIL watchdog: actual %0d cycles expected < %0d", cyc_cnt, WD_CYCLES);
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      txd = 1'b0;
      ot = 1'b0;
      nm = 1'b1;
      cyc(3);
      chk("R1", "drv_en in reset", drv_en, 1'b0);
      chk("R1", "tmo_lock in reset", tmo_lock, 1'b0);
      chk("R1", "therm_lock in reset", therm_lock, 1'b0);
      txd = 1'b1;
      rst_n = 1'b1;
      cyc(1);
      chk("R1", "drv_en after reset release", drv_en, 1'b0);
      cyc(SYNC + 2);
   endtask

   task automatic t_basic();
      nm = 1'b1;
      txd = 1'b0;
      cyc(SYNC - 1);
      chk("R2", "driver before sync latency", drv_en, 1'b0);
      cyc(1);
      chk("R2", "driver on after sync latency", drv_en, 1'b1);
      nm = 1'b0;
      #1;
      chk("R2", "driver off outside normal mode", drv_en, 1'b0);
      nm = 1'b1;
      #1;
      chk("R2", "driver back in normal mode", drv_en, 1'b1);
      cyc(1);
      txd = 1'b1;
      cyc(SYNC);
      chk("R2", "driver off on recessive", drv_en, 1'b0);
      cyc(2);
   endtask

   task automatic t_timeout();
      txd = 1'b0;
      cyc(SYNC + TMO - 1);
      chk("R3", "driver on at last allowed cycle", drv_en, 1'b1);
      chk("R3", "no timeout before expiry", tmo_lock, 1'b0);
      cyc(1);
      chk("R3", "driver off at expiry", drv_en, 1'b0);
      chk("R3", "timeout lock at expiry", tmo_lock, 1'b1);
      cyc(50);
      chk("R4", "timeout lock held while low", tmo_lock, 1'b1);
      txd = 1'b1;
      cyc(SYNC);
      chk("R4", "timeout lock before release edge", tmo_lock, 1'b1);
      cyc(1);
      chk("R4", "timeout lock released", tmo_lock, 1'b0);
      cyc(2);
   endtask

   task automatic t_restart();
      txd = 1'b0;
      cyc(SYNC + 120);
      txd = 1'b1;
      cyc(3);
      chk("R4", "no lock after short low", tmo_lock, 1'b0);
      txd = 1'b0;
      cyc(SYNC + TMO - 1);
      chk("R4", "fresh timer full length", drv_en, 1'b1);
      cyc(1);
      chk("R4", "fresh timer expires", tmo_lock, 1'b1);
      txd = 1'b1;
      cyc(SYNC + 2);
   endtask

   task automatic t_mode();
      nm = 1'b0;
      txd = 1'b0;
      cyc(SYNC + TMO);
      chk("R5", "timeout outside normal mode", tmo_lock, 1'b1);
      nm = 1'b1;
      cyc(1);
      chk("R5", "driver stays off in normal mode", drv_en, 1'b0);
      txd = 1'b1;
      cyc(SYNC + 1);
      chk("R5", "lock released", tmo_lock, 1'b0);
      cyc(2);
   endtask

   task automatic t_thermal();
      nm = 1'b1;
      txd = 1'b0;
      cyc(SYNC);
      chk("R6", "driver on before overtemp", drv_en, 1'b1);
      ot = 1'b1;
      cyc(SYNC);
      chk("R6", "thermal lock before latency", therm_lock, 1'b0);
      cyc(1);
      chk("R6", "thermal lock set", therm_lock, 1'b1);
      chk("R6", "driver off on thermal", drv_en, 1'b0);
      ot = 1'b0;
      cyc(SYNC + 3);
      chk("R7", "thermal lock held after flag drops", therm_lock, 1'b1);
      chk("R7", "driver still off", drv_en, 1'b0);
      txd = 1'b1;
      cyc(SYNC);
      chk("R7", "thermal lock before release edge", therm_lock, 1'b1);
      cyc(1);
      chk("R7", "thermal lock released by high", therm_lock, 1'b0);
      txd = 1'b0;
      cyc(SYNC);
      chk("R7", "driver usable after release", drv_en, 1'b1);
      txd = 1'b1;
      cyc(SYNC + 2);
   endtask

   task automatic t_thermal_priority();
      ot = 1'b1;
      cyc(SYNC + 1);
      chk("R7", "thermal lock set high flag", therm_lock, 1'b1);
      txd = 1'b0;
      cyc(SYNC + 1);
      txd = 1'b1;
      cyc(SYNC + 1);
      chk("R7", "flag high wins over rising txd", therm_lock, 1'b1);
      ot = 1'b0;
      cyc(SYNC + 2);
      chk("R7", "no release without rising txd", therm_lock, 1'b1);
      txd = 1'b0;
      cyc(SYNC);
      txd = 1'b1;
      cyc(SYNC + 1);
      chk("R7", "release on later rising txd", therm_lock, 1'b0);
      cyc(2);
   endtask

   task automatic t_thermal_timeout();
      ot = 1'b1;
      cyc(SYNC + 1);
      txd = 1'b0;
      cyc(SYNC + TMO);
      chk("R8", "timeout runs under thermal lock", tmo_lock, 1'b1);
      chk("R8", "thermal lock still set", therm_lock, 1'b1);
      ot = 1'b0;
      cyc(SYNC + 1);
      txd = 1'b1;
      cyc(SYNC + 1);
      chk("R8", "timeout released", tmo_lock, 1'b0);
      chk("R8", "thermal released", therm_lock, 1'b0);
      cyc(2);
   endtask

   initial begin
      t_reset();
      t_basic();
      t_timeout();
      t_restart();
      t_mode();
      t_thermal();
      t_thermal_priority();
      t_thermal_timeout();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule